// File: doc/BRIEF.md
# Address-Tweaked ECC Storage for Instruction Cache Banks

This block wraps the two storage arrays of an instruction cache: one bank of 64-bit instruction words and one bank of 22-bit tags. Every word is protected by a SEC-DED code. Before a word is stored, an address-derived tweak is XORed into the whole codeword, covering both payload and check bits. On a read, the same tweak is XORed off again before the code is checked.

The tweak ties each stored word to the address it was written for. A word that is fetched through a different address than the one used to write it does not match its check bits, so it is flagged. This happens, for example, when an upper address bit is disturbed while the storage row stays the same.

Errors are only detected, never corrected. The read payload is returned as it comes out of the array after tweak removal. Per-bank error flags are provided, and a single combined alert is raised whenever either bank returns a faulty word.

Top module: `tweaked_ecc_banks`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `dat_rvalid_o`, `tag_rvalid_o`, `dat_err_o`, `tag_err_o` and `ecc_alert_o` are all 0.
- R2: A data request with `dat_we_i`=0 on a rising edge gives `dat_rvalid_o`=1 for exactly the following cycle. A data write request, or no request, gives `dat_rvalid_o`=0 in the following cycle.
- R3: A tag request with `tag_we_i`=0 gives `tag_rvalid_o`=1 for exactly the following cycle. A tag write or no request gives `tag_rvalid_o`=0.
- R4: A data word written at byte address A and read back at A is returned unchanged, with `dat_err_o`=0. The storage row is address bits [9:3].
- R5: A tag written at index I and read back at I is returned unchanged, with `tag_err_o`=0. The tag tweak is the 4-bit index, zero-extended to the 28-bit tag codeword.
- R6: The data tweak is the fetch address with its 6 line-offset bits removed (address bits [31:6]). It is zero-extended to the 72-bit codeword, whose payload occupies bits [63:0] and check bits [71:64]. Suppose a word is written at A and read at an address B that has the same row, where the tweaks of A and B differ in one or two bits. Then `dat_err_o`=1, and `dat_rdata_o` equals the written data XOR the tweak difference restricted to bits [63:0]. No correction is applied.
- R7: `dat_err_o` and `tag_err_o` are 0 whenever the matching read-valid is 0. `ecc_alert_o` is 1 exactly on the cycles where `dat_err_o` or `tag_err_o` is 1.
- R8: The tweak used for checking is the one captured at request time. Back-to-back reads on consecutive cycles each give their own correct data and error result, even when the address changes on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| dat_req_i | input | 1 | Data bank access request |
| dat_we_i | input | 1 | Data access is a write (1) or read (0) |
| dat_addr_i | input | 32 | Fetch byte address for the data access |
| dat_wdata_i | input | 64 | Data payload to write |
| dat_rvalid_o | output | 1 | Data read result valid |
| dat_rdata_o | output | 64 | Data payload read, tweak removed, uncorrected |
| dat_err_o | output | 1 | Data ECC mismatch on this read |
| tag_req_i | input | 1 | Tag bank access request |
| tag_we_i | input | 1 | Tag access is a write (1) or read (0) |
| tag_idx_i | input | 4 | Tag set index |
| tag_wdata_i | input | 22 | Tag payload to write |
| tag_rvalid_o | output | 1 | Tag read result valid |
| tag_rdata_o | output | 22 | Tag payload read, tweak removed, uncorrected |
| tag_err_o | output | 1 | Tag ECC mismatch on this read |
| ecc_alert_o | output | 1 | Combined error pulse from either bank |

## Verification
The assertions check the protocol on every cycle. They cover the one-cycle read latency of both banks, the absence of a valid strobe after writes or idle cycles, error flags that appear only with a valid strobe, the alert that follows either flag, and the quiet outputs after reset. The bench scenarios show what no single-cycle property can: round-trip integrity through the tweak, and detection of reads through an aliasing address. They also show the uncorrected payload with its exact flipped bits, and that captured tweaks stay paired with their words under back-to-back reads.

// File: rtl/tecb_pkg.sv
package tecb_pkg;
    // Geometry of the protected cache storage.
    localparam int ADDR_W       = 32;
    localparam int DATA_W       = 64;
    localparam int DATA_CHK_W   = 8;
    localparam int TAG_W        = 22;
    localparam int TAG_CHK_W    = 6;
    localparam int LINE_W       = 6;   // byte-offset bits of a cache line
    localparam int IDX_W        = 4;   // set index bits
    localparam int WORD_OFF_W   = 3;   // byte-offset bits of one data word
    // Derived widths.
    localparam int DATA_ROW_W   = LINE_W - WORD_OFF_W + IDX_W;
    localparam int DATA_TWK_W   = ADDR_W - LINE_W;
endpackage

// File: rtl/tecb_secded_enc.sv
// Extended-Hamming SEC-DED check-bit generator.
// Payload bit k is assigned to the k-th non-power-of-two position counted
// from 1. The low CHK_W-1 check bits hold the XOR of the positions of all
// set payload bits. The top check bit is the overall parity of payload and
// Hamming bits. Assumes 2**(CHK_W-1) > PAY_W + CHK_W - 1.
module tecb_secded_enc #(
    parameter int PAY_W = 64,
    parameter int CHK_W = 8
) (
    input  logic [PAY_W-1:0] data_i,
    output logic [CHK_W-1:0] chk_o
);
    localparam int HW   = CHK_W - 1;
    localparam int NPOS = 1 << HW;

    logic [HW-1:0] syn;

    // Accumulate the position syndrome of every set payload bit.
    always_comb begin
        int k;
        k   = 0;
        syn = '0;
        for (int p = 1; p < NPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (k < PAY_W) begin
                    if (data_i[k]) syn = syn ^ HW'(p);
                end
                k++;
            end
        end
    end

    // Overall parity bit completes the double-error detection.
    assign chk_o = {(^data_i) ^ (^syn), syn};
endmodule

// File: rtl/tecb_bank.sv
// One tweaked, ECC-protected synchronous RAM bank.
// Write path: encode check bits, then XOR the tweak over the whole codeword
// {check, payload} and store. Read path: the row is read into a register
// together with the request's tweak. One cycle later the tweak is removed,
// the check bits are recomputed and a mismatch is flagged. Memory contents
// are not reset. One access per cycle; a write takes precedence over nothing.
module tecb_bank #(
    parameter int PAY_W = 64,
    parameter int CHK_W = 8,
    parameter int ROW_W = 7,
    parameter int TWK_W = 26
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [TWK_W-1:0] twk_i,
    input  logic [PAY_W-1:0] wdata_i,
    output logic             rvalid_o,
    output logic [PAY_W-1:0] rdata_o,
    output logic             err_o
);
    localparam int CW_W  = PAY_W + CHK_W;
    localparam int DEPTH = 1 << ROW_W;

    logic [CW_W-1:0]  twk_ext;
    logic [CW_W-1:0]  mem [DEPTH];
    logic [CW_W-1:0]  rd_q;
    logic [CW_W-1:0]  twk_q;
    logic             rvalid_q;
    logic [CHK_W-1:0] wr_chk;
    logic [CHK_W-1:0] rd_chk;
    logic [CW_W-1:0]  clear_word;

    // Fit the tweak to the codeword width: truncate or zero-extend.
    generate
        if (TWK_W >= CW_W) begin : g_twk_trunc
            assign twk_ext = twk_i[CW_W-1:0];
        end else begin : g_twk_pad
            assign twk_ext = {{(CW_W - TWK_W){1'b0}}, twk_i};
        end
    endgenerate

    tecb_secded_enc #(.PAY_W(PAY_W), .CHK_W(CHK_W)) u_enc_wr (
        .data_i (wdata_i),
        .chk_o  (wr_chk)
    );

    // Storage array and read register; no reset on data.
    always_ff @(posedge clk_i) begin
        if (req_i && we_i) begin
            mem[row_i] <= {wr_chk, wdata_i} ^ twk_ext;
        end
        if (req_i && !we_i) begin
            rd_q  <= mem[row_i];
            twk_q <= twk_ext;
        end
    end

    // Read-valid strobe, one cycle after a read request.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) rvalid_q <= 1'b0;
        else         rvalid_q <= req_i && !we_i;
    end

    // Remove the captured tweak from the returned codeword.
    assign clear_word = rd_q ^ twk_q;
    assign rdata_o    = clear_word[PAY_W-1:0];

    tecb_secded_enc #(.PAY_W(PAY_W), .CHK_W(CHK_W)) u_enc_rd (
        .data_i (clear_word[PAY_W-1:0]),
        .chk_o  (rd_chk)
    );

    assign rvalid_o = rvalid_q;
    assign err_o    = rvalid_q && (rd_chk != clear_word[CW_W-1:PAY_W]);
endmodule

// File: rtl/tweaked_ecc_banks.sv
// Data and tag storage of an instruction cache with address-tweaked SEC-DED.
// Data tweak: fetch address without the line-offset bits. Tag tweak: set
// index. Errors are detected only; a combined alert pulses with any flagged
// read. Assumes the caller issues at most one access per bank per cycle.
module tweaked_ecc_banks #(
    parameter int ADDR_W     = tecb_pkg::ADDR_W,
    parameter int DATA_W     = tecb_pkg::DATA_W,
    parameter int DATA_CHK_W = tecb_pkg::DATA_CHK_W,
    parameter int TAG_W      = tecb_pkg::TAG_W,
    parameter int TAG_CHK_W  = tecb_pkg::TAG_CHK_W,
    parameter int LINE_W     = tecb_pkg::LINE_W,
    parameter int IDX_W      = tecb_pkg::IDX_W,
    parameter int WORD_OFF_W = tecb_pkg::WORD_OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dat_req_i,
    input  logic              dat_we_i,
    input  logic [ADDR_W-1:0] dat_addr_i,
    input  logic [DATA_W-1:0] dat_wdata_i,
    output logic              dat_rvalid_o,
    output logic [DATA_W-1:0] dat_rdata_o,
    output logic              dat_err_o,
    input  logic              tag_req_i,
    input  logic              tag_we_i,
    input  logic [IDX_W-1:0]  tag_idx_i,
    input  logic [TAG_W-1:0]  tag_wdata_i,
    output logic              tag_rvalid_o,
    output logic [TAG_W-1:0]  tag_rdata_o,
    output logic              tag_err_o,
    output logic              ecc_alert_o
);
    localparam int ROW_W = LINE_W - WORD_OFF_W + IDX_W;
    localparam int TWK_W = ADDR_W - LINE_W;

    logic [ROW_W-1:0] dat_row;
    logic [TWK_W-1:0] dat_twk;

    // Row selects word within the set's line; tweak is the line address.
    assign dat_row = dat_addr_i[WORD_OFF_W +: ROW_W];
    assign dat_twk = dat_addr_i[ADDR_W-1:LINE_W];

    tecb_bank #(
        .PAY_W (DATA_W),
        .CHK_W (DATA_CHK_W),
        .ROW_W (ROW_W),
        .TWK_W (TWK_W)
    ) u_data_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (dat_req_i),
        .we_i     (dat_we_i),
        .row_i    (dat_row),
        .twk_i    (dat_twk),
        .wdata_i  (dat_wdata_i),
        .rvalid_o (dat_rvalid_o),
        .rdata_o  (dat_rdata_o),
        .err_o    (dat_err_o)
    );

    tecb_bank #(
        .PAY_W (TAG_W),
        .CHK_W (TAG_CHK_W),
        .ROW_W (IDX_W),
        .TWK_W (IDX_W)
    ) u_tag_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (tag_req_i),
        .we_i     (tag_we_i),
        .row_i    (tag_idx_i),
        .twk_i    (tag_idx_i),
        .wdata_i  (tag_wdata_i),
        .rvalid_o (tag_rvalid_o),
        .rdata_o  (tag_rdata_o),
        .err_o    (tag_err_o)
    );

    // Either bank's mismatch raises the shared alert in the same cycle.
    assign ecc_alert_o = dat_err_o || tag_err_o;
endmodule

// File: rtl/tecb_checker.sv
// Protocol properties of tweaked_ecc_banks, attached by bind.
module tecb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 22,
    parameter int IDX_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              dat_req_i,
    input logic              dat_we_i,
    input logic              dat_rvalid_o,
    input logic              dat_err_o,
    input logic              tag_req_i,
    input logic              tag_we_i,
    input logic              tag_rvalid_o,
    input logic              tag_err_o,
    input logic              ecc_alert_o
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk_i)
        !rst_ni |=> !dat_rvalid_o && !tag_rvalid_o && !ecc_alert_o);

    assert_dat_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_req_i && !dat_we_i) |=> dat_rvalid_o);

    assert_dat_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dat_req_i && !dat_we_i) |=> !dat_rvalid_o);

    assert_tag_read_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tag_req_i && !tag_we_i) |=> tag_rvalid_o);

    assert_tag_no_spurious_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(tag_req_i && !tag_we_i) |=> !tag_rvalid_o);

    assert_err_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_err_o |-> dat_rvalid_o) and (tag_err_o |-> tag_rvalid_o));

    assert_alert_follows_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_err_o || tag_err_o) |-> ecc_alert_o);

    assert_alert_has_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ecc_alert_o |-> (dat_rvalid_o || tag_rvalid_o));
endmodule

bind tweaked_ecc_banks tecb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .IDX_W  (IDX_W)
) u_tecb_checker (.*);

// File: tb/tweaked_ecc_banks_test.sv
module tweaked_ecc_banks_test;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        dat_req, dat_we;
    logic [31:0] dat_addr;
    logic [63:0] dat_wdata;
    logic        dat_rvalid;
    logic [63:0] dat_rdata;
    logic        dat_err;
    logic        tag_req, tag_we;
    logic [3:0]  tag_idx;
    logic [21:0] tag_wdata;
    logic        tag_rvalid;
    logic [21:0] tag_rdata;
    logic        tag_err;
    logic        alert;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Scoreboard queues: {err, data} plus requirement tag.
    logic [64:0] dat_exp_q[$];
    string       dat_tag_q[$];
    logic [22:0] tag_exp_q[$];
    string       tag_tag_q[$];

    // Reference contents: payload and write-time line address per row.
    logic [63:0] dmod_data [logic [6:0]];
    logic [25:0] dmod_line [logic [6:0]];
    logic [21:0] tmod [logic [3:0]];

    tweaked_ecc_banks uut (
        .clk_i(clk), .rst_ni(rst_n),
        .dat_req_i(dat_req), .dat_we_i(dat_we), .dat_addr_i(dat_addr),
        .dat_wdata_i(dat_wdata), .dat_rvalid_o(dat_rvalid),
        .dat_rdata_o(dat_rdata), .dat_err_o(dat_err),
        .tag_req_i(tag_req), .tag_we_i(tag_we), .tag_idx_i(tag_idx),
        .tag_wdata_i(tag_wdata), .tag_rvalid_o(tag_rvalid),
        .tag_rdata_o(tag_rdata), .tag_err_o(tag_err),
        .ecc_alert_o(alert)
    );

    initial clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        dat_req = 0; dat_we = 0; dat_addr = '0; dat_wdata = '0;
        tag_req = 0; tag_we = 0; tag_idx = '0; tag_wdata = '0;
    endtask

    // Advance to the next falling edge and drop all requests.
    task automatic tick();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic d_write(input logic [31:0] a, input logic [63:0] d);
        dat_req = 1; dat_we = 1; dat_addr = a; dat_wdata = d;
        dmod_data[a[9:3]] = d;
        dmod_line[a[9:3]] = a[31:6];
    endtask

    task automatic d_read(input logic [31:0] a, input string req);
        logic [25:0] diff;
        logic [63:0] exp;
        dat_req = 1; dat_we = 0; dat_addr = a;
        diff = dmod_line[a[9:3]] ^ a[31:6];
        exp  = dmod_data[a[9:3]] ^ {38'd0, diff};
        dat_exp_q.push_back({diff != 0, exp});
        dat_tag_q.push_back(req);
    endtask

    task automatic t_write(input logic [3:0] i, input logic [21:0] d);
        tag_req = 1; tag_we = 1; tag_idx = i; tag_wdata = d;
        tmod[i] = d;
    endtask

    task automatic t_read(input logic [3:0] i, input string req);
        tag_req = 1; tag_we = 0; tag_idx = i;
        tag_exp_q.push_back({1'b0, tmod[i]});
        tag_tag_q.push_back(req);
    endtask

    // Monitor: pop expected results as read strobes appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic exp_derr, exp_terr;
            exp_derr = 0; exp_terr = 0;
            if (dat_rvalid) begin
                if (dat_exp_q.size() == 0) begin
                    check(0, "R2", "unexpected data valid", 64'd1, 64'd0);
                end else begin
                    logic [64:0] e;
                    string r;
                    e = dat_exp_q.pop_front();
                    r = dat_tag_q.pop_front();
                    exp_derr = e[64];
                    check(dat_rdata == e[63:0], r, "data payload", dat_rdata, e[63:0]);
                    check(dat_err == e[64], r, "data error flag", {63'd0, dat_err}, {63'd0, e[64]});
                end
            end else begin
                check(!dat_err, "R7", "data err without valid", {63'd0, dat_err}, 64'd0);
            end
            if (tag_rvalid) begin
                if (tag_exp_q.size() == 0) begin
                    check(0, "R3", "unexpected tag valid", 64'd1, 64'd0);
                end else begin
                    logic [22:0] e;
                    string r;
                    e = tag_exp_q.pop_front();
                    r = tag_tag_q.pop_front();
                    exp_terr = e[22];
                    check(tag_rdata == e[21:0], r, "tag payload", {42'd0, tag_rdata}, {42'd0, e[21:0]});
                    check(tag_err == e[22], r, "tag error flag", {63'd0, tag_err}, {63'd0, e[22]});
                end
            end else begin
                check(!tag_err, "R7", "tag err without valid", {63'd0, tag_err}, 64'd0);
            end
            check(alert == (exp_derr || exp_terr), "R7", "alert",
                  {63'd0, alert}, {63'd0, exp_derr || exp_terr});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset.
        check(!dat_rvalid && !tag_rvalid && !dat_err && !tag_err && !alert, "R1",
              "outputs in reset", {59'd0, dat_rvalid, tag_rvalid, dat_err, tag_err, alert}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        // R1: still quiet one cycle after reset release.
        check(!dat_rvalid && !tag_rvalid && !alert, "R1", "outputs after reset",
              {61'd0, dat_rvalid, tag_rvalid, alert}, 64'd0);

        // Fill eight data rows and all tag sets concurrently.
        for (int i = 0; i < 8; i++) begin
            d_write(32'h1000_0000 + 32'(i * 8) + 32'(i * 64),
                    {32'hA5A5_0000 + 32'(i), 32'h0F0F_F0F0 ^ 32'(i * 17)});
            t_write(4'(i), 22'h15_5555 ^ 22'(i * 3));
            tick();
        end
        for (int i = 8; i < 16; i++) begin
            t_write(4'(i), 22'(i * 12345));
            tick();
        end
        d_write(32'h2000_0010, 64'd0);
        tick();
        d_write(32'h2000_0018, 64'hFFFF_FFFF_FFFF_FFFF);
        tick();
        tick();  // R2: idle cycles after writes produce no valid.

        // R4 R5 R8: back-to-back reads on both banks.
        for (int i = 0; i < 8; i++) begin
            d_read(32'h1000_0000 + 32'(i * 8) + 32'(i * 64), "R4");
            t_read(4'(i), "R5");
            tick();
        end
        for (int i = 8; i < 16; i++) begin
            t_read(4'(i), "R3");
            tick();
        end
        d_read(32'h2000_0010, "R4");
        tick();
        d_read(32'h2000_0018, "R4");
        tick();

        // R6: alias reads, one and two tweak bits different.
        d_read(32'h2000_0010 ^ 32'h0000_0400, "R6");
        tick();
        d_read(32'h2000_0018 ^ 32'h0200_1000, "R6");
        tick();
        d_read(32'h1000_0000 ^ 32'h8000_0000, "R6");
        t_read(4'd3, "R5");
        tick();

        // R8: alias read followed at once by correct reads, and the reverse.
        d_read(32'h1000_0048 ^ 32'h0010_0000, "R8");
        tick();
        d_read(32'h1000_0048, "R8");
        tick();
        d_read(32'h2000_0010, "R8");
        tick();
        d_read(32'h2000_0010 ^ 32'h0004_0000, "R8");
        tick();

        // R4: overwrite a row through a new line address, then read.
        d_write(32'h3000_0010, 64'h0123_4567_89AB_CDEF);
        tick();
        d_read(32'h3000_0010, "R4");
        tick();
        d_read(32'h2000_0010, "R6");
        tick();

        repeat (3) tick();
        check(dat_exp_q.size() == 0, "R2", "pending data reads", 64'(dat_exp_q.size()), 64'd0);
        check(tag_exp_q.size() == 0, "R3", "pending tag reads", 64'(tag_exp_q.size()), 64'd0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule